// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst on a synchronous memory. An external starting address is registered whenever either of two independent active-low address strobes is seen low at a rising clock edge. The block then steps a two-bit beat counter once for every clock edge at which the active-low advance input is low.

The current address is the upper address bits captured at the load, joined with two low bits. The low bits follow one of two burst orderings. In linear ordering the start offset is incremented modulo four. In interleaved ordering the start offset is XOR-ed with the beat count. The ordering select is sampled together with the address, so one burst keeps a single ordering from start to end.

The storage array, the data paths and write control belong to the surrounding memory. They are not part of this block.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), addr_out is all zeros. The beat count is zero and the captured ordering is interleaved.
- R2: If strobe_p_n or strobe_c_n is low at a rising edge, addr_out after that edge equals addr_in as sampled at that edge. Either strobe alone is enough.
- R3: With order_sel low at load time (linear ordering), the low two bits of addr_out are (start + beat) mod 4. Here start is addr_in[1:0] at load and beat is the number of advances since that load.
- R4: With order_sel high at load time (interleaved ordering), the low two bits of addr_out are start XOR beat.
- R5: Each rising edge with adv_n low and both strobes high advances beat by one. After the fourth advance the beat wraps to zero and the address returns to the start address.
- R6: At an edge with both strobes high and adv_n high, addr_out keeps its value, whatever addr_in and order_sel do.
- R7: A strobe takes precedence over advance. A strobe at an edge where adv_n is also low loads the new address with beat zero and does not step.
- R8: The upper ADDR_W-2 bits of addr_out change only at a load. They equal the upper bits of addr_in at that load.
- R9: order_sel is sampled only at a load. Changing it during a burst has no effect on the ordering of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | Starting word address, sampled at a strobe |
| strobe_p_n | input | 1 | First address strobe, active low |
| strobe_c_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst ordering: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current burst word address |

## Verification
Every result appears one clock edge after the inputs that cause it. A load, an advance or a hold sampled at edge N shows on addr_out right after edge N, because the address path after the registers is purely combinational. The bench changes inputs on the falling edge and samples addr_out one time unit after the next rising edge. Each check therefore sees exactly one edge's effect. Expected addresses are computed arithmetically from the start offset, the beat count and the ordering for every start offset, both orderings and both strobes.

// File: rtl/bas_pkg.sv
// Package: shared types and constants of the burst address sequencer.
// Assumes a fixed four-beat burst, so the beat counter is two bits wide.
package bas_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/bas_load_reg.sv
// Module: bas_load_reg
// Holds the burst base: upper address bits, start offset and burst ordering.
// Assumes load is already the OR of both strobes; reset is synchronous, active low.
module bas_load_reg
    import bas_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int UP_W = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_sel,
    output logic [UP_W-1:0]   upper_q,
    output beat_t             start_q,
    output order_e            order_q
);
    // Capture the base address and the ordering at each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            order_q <= ORD_INTERLEAVE;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:BEAT_W];
            start_q <= addr_in[BEAT_W-1:0];
            order_q <= order_e'(order_sel);
        end
    end

    // R9: the ordering only changes at a load
    a_r9_order_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(order_q));
endmodule

// File: rtl/bas_beat_ctr.sv
// Module: bas_beat_ctr
// Counts burst beats; clears on load, steps on advance, wraps modulo 2**BEAT_W.
// Assumes load has priority over advance.
module bas_beat_ctr
    import bas_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  adv,
    output beat_t beat_q
);
    // Clear on load or reset, otherwise step when advance is active.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            beat_q <= '0;
        end else if (adv) begin
            beat_q <= beat_q + beat_t'(1);
        end
    end

    // R5: one step per advance, wrapping
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> beat_q == beat_t'($past(beat_q) + beat_t'(1)));
    // R6: no step without advance or load
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(beat_q));
    // R7: load wins over advance
    a_r7_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> beat_q == '0);
endmodule

// File: rtl/bas_order_map.sv
// Module: bas_order_map
// Combinational: maps start offset and beat count to the low address bits.
// Linear adds modulo 2**BEAT_W; interleaved applies a bitwise XOR.
module bas_order_map
    import bas_pkg::*;
(
    input  beat_t  start,
    input  beat_t  beat,
    input  order_e order,
    output beat_t  low
);
    beat_t lin_low;
    beat_t ilv_low;

    // Compute both orderings and select by the captured mode.
    always_comb begin
        lin_low = start + beat;
        for (int i = 0; i < BEAT_W; i++) begin
            ilv_low[i] = start[i] ^ beat[i];
        end
        low = (order == ORD_LINEAR) ? lin_low : ilv_low;
    end

    // When beat is zero, both orderings give the start offset.
    always_comb begin
        if (beat == '0) begin
            a_r2_zero_map: assert (low == start);
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Burst address sequencer: a load on either active-low strobe, steps on
// active-low advance, linear or interleaved low-bit ordering.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int UP_W = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);
    logic      load;
    logic      adv;
    logic [UP_W-1:0] upper_q;
    beat_t     start_q;
    beat_t     beat_q;
    beat_t     low;
    order_e    order_q;

    // Decode the active-low strobes and the advance input.
    always_comb begin
        load = !strobe_p_n || !strobe_c_n;
        adv  = !adv_n;
    end

    bas_load_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk(clk), .rst_n(rst_n), .load(load), .addr_in(addr_in),
        .order_sel(order_sel), .upper_q(upper_q), .start_q(start_q),
        .order_q(order_q)
    );

    bas_beat_ctr u_beat (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .beat_q(beat_q)
    );

    bas_order_map u_map (
        .start(start_q), .beat(beat_q), .order(order_q), .low(low)
    );

    // Join the held upper bits with the sequenced low bits.
    always_comb begin
        addr_out = {upper_q, low};
    end

    // R2: a strobe loads the presented address
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr_out == $past(addr_in));
    // R8: upper bits move only at a load
    a_r8_upper: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));
    // R6: nothing changes without a strobe or an advance
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(addr_out));
endmodule

// File: tb/sim_burst_addr_seq.sv
// Bench: sweeps both orderings, all start offsets and both strobes, and checks
// every address against arithmetic expectations.
module sim_burst_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_p_n = 1'b1;
    logic          strobe_c_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b1;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_p_n(strobe_p_n),
        .strobe_c_n(strobe_c_n), .adv_n(adv_n), .order_sel(order_sel),
        .addr_out(addr_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [1:0] exp_low(input logic m, input logic [1:0] s,
                                           input logic [1:0] b);
        return m ? (s ^ b) : 2'(s + b);
    endfunction

    task automatic check(input string req, input logic [AW-1:0] exp);
        checks++;
        if (addr_out !== exp) begin
            errors++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    // Drive at the falling edge, then sample just after the next rising edge.
    task automatic cycle(input logic sp, input logic sc, input logic av,
                         input logic m, input logic [AW-1:0] a);
        @(negedge clk);
        strobe_p_n = sp; strobe_c_n = sc; adv_n = av; order_sel = m; addr_in = a;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        logic [AW-1:0] other;
        cycle(1, 1, 1, 1, 16'hFFFF);
        cycle(1, 1, 1, 1, 16'hFFFF);
        check("R1", '0);
        @(negedge clk) rst_n = 1'b1;
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int k = 0; k < 2; k++) begin
                    base = {14'((m * 8 + s * 2 + k) * 16'h0123 + 16'h0041), 2'(s)};
                    other = ~base;
                    // R2: load through one strobe, with advance idle
                    cycle(k == 0, k == 1, 1, 1'(m), base);
                    check("R2", base);
                    for (int b = 1; b <= 4; b++) begin
                        // R3/R4/R5: advance by one beat
                        cycle(1, 1, 0, 1'(m), other);
                        check(m ? "R4" : "R3", {base[AW-1:2], exp_low(1'(m), 2'(s), 2'(b))});
                        // R6/R8/R9: hold while inputs and ordering change
                        cycle(1, 1, 1, 1'(~m), other);
                        check("R6", {base[AW-1:2], exp_low(1'(m), 2'(s), 2'(b))});
                    end
                    // R5: after four advances the start address is back
                    check("R5", base);
                    // R9: mid-burst ordering change is ignored
                    cycle(1, 1, 0, 1'(~m), other);
                    check("R9", {base[AW-1:2], exp_low(1'(m), 2'(s), 2'd1)});
                    cycle(1, 1, 0, 1'(~m), other);
                    check("R8", {base[AW-1:2], exp_low(1'(m), 2'(s), 2'd2)});
                    // R7: a strobe with advance low loads and does not step
                    cycle(k == 1, k == 0, 0, 1'(m), other);
                    check("R7", other);
                    cycle(1, 1, 0, 1'(m), base);
                    check("R7", {other[AW-1:2], exp_low(1'(m), other[1:0], 2'd1)});
                end
            end
        end
        // R2: both strobes together also load
        cycle(0, 0, 1, 0, 16'hBEE6);
        check("R2", 16'hBEE6);
        // R1: reset mid-burst clears the address
        @(negedge clk) rst_n = 1'b0;
        cycle(1, 1, 0, 0, 16'h1234);
        check("R1", '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule